// File: doc/BRIEF.md
# Debug Breakpoint Context Swap Controller

This block is the debug-trap unit of a small stack-based processor core. It receives instructions that are already decoded, together with the operand register, the current priority level, the running process's workspace and instruction pointers, and the base address of a reserved save area. For a break it exchanges the running pointer pair with a pair held in that area. The save area holds one pair for each priority level. The pair for high priority sits at words 0 and 1, and the pair for low priority sits at words 2 and 3. The block reaches the save area through a single-port, word-addressed memory port.

The block owns a break-enable flag that software can set and clear. While the flag is set, a relative jump with a zero offset becomes a context swap. Every other jump simply moves the instruction pointer by the offset. A dedicated break opcode swaps whatever the flag holds, so a debugger can clear the flag and still hand control back to the user process. Each instruction has a fixed latency. The block reports completion with a one-cycle done pulse, and it ignores any new instruction while it is busy.

Top module: `brk_ctx_swap`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears the break-enable flag (brk_en = 0), busy, done and both output pointers. It makes no memory access.
- R2: Secondary code 0xB3 (op_sec = 1) sets brk_en and secondary code 0xB2 clears it. Each takes 1 cycle: done is high in the cycle that follows the accepting edge. wptr_out and iptr_out then equal the wptr_in and iptr_in that were presented with the code.
- R3: Primary code 0x00 (op_sec = 0) with brk_en clear, or with a nonzero oreg, is a plain jump that takes 3 cycles. It gives iptr_out = iptr_in + oreg (modulo 2^32) and wptr_out = wptr_in, and it makes no memory access.
- R4: Primary code 0x00 with brk_en set and oreg equal to zero performs the context swap. It takes 11 cycles at high priority (prio_low = 0) and 13 cycles at low priority.
- R5: Secondary code 0xB1 performs the context swap whatever the state of brk_en. It takes 9 cycles at high priority and 11 cycles at low priority.
- R6: A swap uses word index k = 0 at high priority and k = 2 at low priority. Word n lies at byte address base_addr + 4*n. The swap stores the old wptr_in at word k and the old iptr_in at word k+1. Its outputs are the values those two words held before the swap. The block accesses memory only while busy.
- R7: A swap performs exactly four accesses in this order: read word k, read word k+1, write word k, write word k+1. A read and a write never share a cycle.
- R8: An instruction of N cycles that is accepted at a clock edge keeps busy high for the N-1 cycles after that edge. Done is then high for exactly one cycle, with busy low. op_valid is ignored while busy is high, but an instruction presented in the done cycle is accepted.
- R9: Any code other than primary 0x00 and secondary 0xB1, 0xB2 and 0xB3 is ignored. It raises neither busy nor done, leaves brk_en unchanged and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A decoded instruction is presented |
| op_sec | input | 1 | 1 = secondary code, 0 = primary code |
| op_code | input | 8 | Instruction code |
| oreg | input | 32 | Operand register value (jump offset) |
| prio_low | input | 1 | 1 = running at low priority |
| base_addr | input | 32 | Byte address of the reserved save area |
| wptr_in | input | 32 | Current workspace pointer |
| iptr_in | input | 32 | Current instruction pointer (already at the next instruction) |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse: the output pointers are valid |
| brk_en | output | 1 | Break-enable flag |
| wptr_out | output | 32 | New workspace pointer |
| iptr_out | output | 32 | New instruction pointer |
| mem_rd | output | 1 | Memory read request; data is returned one cycle later |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |

## Verification
Two things can fall in the same cycle. One is the done pulse of one instruction. The other is the presentation of the next instruction, which must be taken, while an instruction presented during busy must be dropped. The bench presents each new instruction in the done cycle of the previous one. In the middle of a swap it injects a flag-toggling code, then checks that the flag is unchanged at the done pulse and that the following instruction runs with the latency the reference model predicts. Busy and done are compared against the model on every cycle, and the memory access log is compared in order.

// File: rtl/brk_ctx_pkg.sv
// Package for the breakpoint context swap controller.
// Holds the instruction codes and the instruction class type that the decoder and the datapath share.
package brk_ctx_pkg;
    localparam logic [7:0] OPC_JUMP     = 8'h00;
    localparam logic [7:0] OPC_BREAK    = 8'hB1;
    localparam logic [7:0] OPC_FLAG_CLR = 8'hB2;
    localparam logic [7:0] OPC_FLAG_SET = 8'hB3;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_SET,
        KIND_CLR,
        KIND_JUMP,
        KIND_SWAP
    } op_kind_t;
endpackage

// File: rtl/brk_decode.sv
// Instruction classifier.
// Maps the presented code to an instruction class and its fixed latency.
// Assumes the operand register is fully built and brk_en is the current flag state.
module brk_decode #(
    parameter int DW         = 32,
    parameter int CW         = 4,
    parameter int CYC_FLAG   = 1,
    parameter int CYC_JUMP   = 3,
    parameter int CYC_J0_HI  = 11,
    parameter int CYC_J0_LO  = 13,
    parameter int CYC_BRK_HI = 9,
    parameter int CYC_BRK_LO = 11
) (
    input  logic                  op_sec,
    input  logic [7:0]            op_code,
    input  logic [DW-1:0]         oreg,
    input  logic                  flag,
    input  logic                  prio_low,
    output brk_ctx_pkg::op_kind_t kind,
    output logic [CW-1:0]         ncyc
);
    import brk_ctx_pkg::*;

    // Classify the instruction and select its latency.
    always_comb begin
        kind = KIND_NONE;
        ncyc = '0;
        if (op_sec) begin
            if (op_code == OPC_FLAG_SET) begin
                kind = KIND_SET;
                ncyc = CW'(CYC_FLAG);
            end else if (op_code == OPC_FLAG_CLR) begin
                kind = KIND_CLR;
                ncyc = CW'(CYC_FLAG);
            end else if (op_code == OPC_BREAK) begin
                kind = KIND_SWAP;
                ncyc = prio_low ? CW'(CYC_BRK_LO) : CW'(CYC_BRK_HI);
            end
        end else if (op_code == OPC_JUMP) begin
            if (flag && (oreg == '0)) begin
                kind = KIND_SWAP;
                ncyc = prio_low ? CW'(CYC_J0_LO) : CW'(CYC_J0_HI);
            end else begin
                kind = KIND_JUMP;
                ncyc = CW'(CYC_JUMP);
            end
        end
    end
endmodule

// File: rtl/brk_en_flag.sv
// Break-enable flag register.
// Assumes set and clr are never high together (they come from distinct instruction classes).
module brk_en_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/brk_sequencer.sv
// Latency sequencer.
// Counts the cycles of an accepted instruction and produces busy, done and the current step number.
// Assumes ncyc >= 1. A one-cycle instruction finishes at its accepting edge.
module brk_sequencer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] ncyc,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] step,
    output logic          fin_imm,
    output logic          fin_busy
);
    logic [CW-1:0] lim_q;

    // Edges at which the output pointers must be loaded.
    always_comb begin
        fin_imm  = start && (ncyc == CW'(1));
        fin_busy = busy && (step == lim_q - CW'(1));
    end

    // Step counter, busy window and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            step  <= '0;
            lim_q <= '0;
        end else begin
            done <= 1'b0;
            if (fin_imm) begin
                done <= 1'b1;
            end else if (start) begin
                busy  <= 1'b1;
                step  <= CW'(1);
                lim_q <= ncyc;
            end else if (fin_busy) begin
                busy <= 1'b0;
                done <= 1'b1;
                step <= '0;
            end else if (busy) begin
                step <= step + CW'(1);
            end
        end
    end
endmodule

// File: rtl/brk_swap_path.sv
// Pointer datapath and save-area memory port.
// Latches the operands at acceptance. During a swap it reads both saved words,
// then writes the old pointers, then presents the new pointer pair on completion.
// Assumes read data returns one cycle after mem_rd, and a swap spans at least 4 busy steps.
module brk_swap_path #(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  brk_ctx_pkg::op_kind_t kind,
    input  logic                  prio_low,
    input  logic [DW-1:0]         base_addr,
    input  logic [DW-1:0]         wptr_in,
    input  logic [DW-1:0]         iptr_in,
    input  logic [DW-1:0]         oreg,
    input  logic                  busy,
    input  logic [CW-1:0]         step,
    input  logic                  fin_imm,
    input  logic                  fin_busy,
    input  logic [DW-1:0]         mem_rdata,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wdata,
    output logic [DW-1:0]         wptr_out,
    output logic [DW-1:0]         iptr_out
);
    import brk_ctx_pkg::*;

    logic          swap_q, jump_q, lo_q;
    logic [DW-1:0] base_q, w_old_q, i_old_q, tgt_q, w_new_q, i_new_q;
    logic          act, second;
    logic [1:0]    idx;

    // Memory command for the current step.
    always_comb begin
        act       = busy && swap_q;
        second    = (step == CW'(2)) || (step == CW'(4));
        mem_rd    = act && ((step == CW'(1)) || (step == CW'(2)));
        mem_wr    = act && ((step == CW'(3)) || (step == CW'(4)));
        idx       = {lo_q, second};
        mem_addr  = base_q + {{(DW-4){1'b0}}, idx, 2'b00};
        mem_wdata = second ? i_old_q : w_old_q;
    end

    // Latch operands at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q  <= 1'b0;
            jump_q  <= 1'b0;
            lo_q    <= 1'b0;
            base_q  <= '0;
            w_old_q <= '0;
            i_old_q <= '0;
            tgt_q   <= '0;
        end else if (start) begin
            swap_q  <= (kind == KIND_SWAP);
            jump_q  <= (kind == KIND_JUMP);
            lo_q    <= prio_low;
            base_q  <= base_addr;
            w_old_q <= wptr_in;
            i_old_q <= iptr_in;
            tgt_q   <= iptr_in + oreg;
        end
    end

    // Capture the saved words as they return from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_new_q <= '0;
            i_new_q <= '0;
        end else begin
            if (act && (step == CW'(2))) w_new_q <= mem_rdata;
            if (act && (step == CW'(3))) i_new_q <= mem_rdata;
        end
    end

    // Present the resulting pointers at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_out <= '0;
            iptr_out <= '0;
        end else if (fin_imm) begin
            wptr_out <= wptr_in;
            iptr_out <= iptr_in;
        end else if (fin_busy) begin
            wptr_out <= swap_q ? w_new_q : w_old_q;
            iptr_out <= swap_q ? i_new_q : (jump_q ? tgt_q : i_old_q);
        end
    end
endmodule

// File: rtl/brk_ctx_swap.sv
// Breakpoint context swap controller (top).
// Accepts a decoded instruction while idle. Executes flag set/clear, plain jump or a
// priority-indexed pointer swap with a save area, each with a fixed latency.
// Assumes the memory port returns read data one cycle after the request.
module brk_ctx_swap #(
    parameter int DW         = 32,
    parameter int CYC_FLAG   = 1,
    parameter int CYC_JUMP   = 3,
    parameter int CYC_J0_HI  = 11,
    parameter int CYC_J0_LO  = 13,
    parameter int CYC_BRK_HI = 9,
    parameter int CYC_BRK_LO = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_sec,
    input  logic [7:0]    op_code,
    input  logic [DW-1:0] oreg,
    input  logic          prio_low,
    input  logic [DW-1:0] base_addr,
    input  logic [DW-1:0] wptr_in,
    input  logic [DW-1:0] iptr_in,
    output logic          busy,
    output logic          done,
    output logic          brk_en,
    output logic [DW-1:0] wptr_out,
    output logic [DW-1:0] iptr_out,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import brk_ctx_pkg::*;

    localparam int MAX_A = (CYC_J0_HI > CYC_J0_LO) ? CYC_J0_HI : CYC_J0_LO;
    localparam int MAX_B = (CYC_BRK_HI > CYC_BRK_LO) ? CYC_BRK_HI : CYC_BRK_LO;
    localparam int MAX_C = (CYC_JUMP > CYC_FLAG) ? CYC_JUMP : CYC_FLAG;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CW    = $clog2(MAXC + 1);

    op_kind_t      kind;
    logic [CW-1:0] ncyc, step;
    logic          accept, fin_imm, fin_busy;

    // Acceptance: a known instruction presented while idle.
    always_comb accept = op_valid && !busy && (kind != KIND_NONE);

    brk_decode #(
        .DW(DW), .CW(CW), .CYC_FLAG(CYC_FLAG), .CYC_JUMP(CYC_JUMP),
        .CYC_J0_HI(CYC_J0_HI), .CYC_J0_LO(CYC_J0_LO),
        .CYC_BRK_HI(CYC_BRK_HI), .CYC_BRK_LO(CYC_BRK_LO)
    ) u_decode (
        .op_sec(op_sec), .op_code(op_code), .oreg(oreg), .flag(brk_en),
        .prio_low(prio_low), .kind(kind), .ncyc(ncyc)
    );

    brk_en_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .set(accept && (kind == KIND_SET)),
        .clr(accept && (kind == KIND_CLR)),
        .flag(brk_en)
    );

    brk_sequencer #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .ncyc(ncyc),
        .busy(busy), .done(done), .step(step),
        .fin_imm(fin_imm), .fin_busy(fin_busy)
    );

    brk_swap_path #(.DW(DW), .CW(CW)) u_path (
        .clk(clk), .rst_n(rst_n), .start(accept), .kind(kind),
        .prio_low(prio_low), .base_addr(base_addr), .wptr_in(wptr_in),
        .iptr_in(iptr_in), .oreg(oreg), .busy(busy), .step(step),
        .fin_imm(fin_imm), .fin_busy(fin_busy), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wptr_out(wptr_out), .iptr_out(iptr_out)
    );
endmodule

// File: rtl/brk_ctx_swap_chk.sv
// Protocol checker for brk_ctx_swap, attached with bind.
// Observes only the top-level ports.
module brk_ctx_swap_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic brk_en,
    input logic mem_rd,
    input logic mem_wr
);
    AST_FLAG_RESET: assert property (@(posedge clk) !rst_n |=> !brk_en); // R1
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R7
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !$past(mem_wr)) |-> ($past(mem_rd, 1) && $past(mem_rd, 2))); // R7
    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr)); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R8
    AST_FLAG_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(brk_en)); // R8
endmodule

bind brk_ctx_swap brk_ctx_swap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .brk_en(brk_en), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/test_brk_ctx_swap.sv
`timescale 1ns/1ps
module test_brk_ctx_swap;
    typedef struct packed {
        logic        wr;
        logic [31:0] a;
        logic [31:0] d;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_sec = 1'b0, prio_low = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [31:0] oreg = '0, base_addr = '0, wptr_in = '0, iptr_in = '0;
    logic        busy, done, brk_en, mem_rd, mem_wr;
    logic [31:0] wptr_out, iptr_out, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem_m [logic [31:0]];
    acc_t        log_q [$];
    int          checks = 0, errors = 0;
    bit          exp_en = 1'b0;

    localparam logic [31:0] BASE = 32'h0000_1000;

    always #2.5 clk = ~clk;

    brk_ctx_swap i_brk_ctx_swap (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sec(op_sec),
        .op_code(op_code), .oreg(oreg), .prio_low(prio_low),
        .base_addr(base_addr), .wptr_in(wptr_in), .iptr_in(iptr_in),
        .busy(busy), .done(done), .brk_en(brk_en), .wptr_out(wptr_out),
        .iptr_out(iptr_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural save-area memory with one-cycle read latency and an access log.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
        if (mem_wr) mem_m[mem_addr] = mem_wdata;
        if (mem_rd || mem_wr) log_q.push_back('{wr: mem_wr, a: mem_addr, d: mem_wdata});
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_m(input logic [31:0] a);
        return mem_m.exists(a) ? mem_m[a] : 32'h0;
    endfunction

    // Drive one instruction in the current cycle and compare against the model every cycle.
    task automatic run_op(input logic sec, input logic [7:0] code, input logic [31:0] ov,
                          input logic lo, input logic [31:0] wv, input logic [31:0] iv,
                          input bit poke, input string req);
        int          n = 0;
        bit          swap = 0, nxt_en = exp_en;
        logic [31:0] ew = wv, ei = iv, a0, a1;
        a0 = BASE + (lo ? 32'd8 : 32'd0);
        a1 = a0 + 32'd4;
        if (sec && code == 8'hB3) begin n = 1; nxt_en = 1'b1; end
        else if (sec && code == 8'hB2) begin n = 1; nxt_en = 1'b0; end
        else if (sec && code == 8'hB1) begin n = lo ? 11 : 9; swap = 1; end
        else if (!sec && code == 8'h00) begin
            if (exp_en && ov == 0) begin n = lo ? 13 : 11; swap = 1; end
            else begin n = 3; ei = iv + ov; end
        end
        if (swap) begin ew = rd_m(a0); ei = rd_m(a1); end
        log_q.delete();
        op_valid = 1'b1; op_sec = sec; op_code = code; oreg = ov;
        prio_low = lo; base_addr = BASE; wptr_in = wv; iptr_in = iv;
        for (int k = 1; k <= ((n == 0) ? 4 : n); k++) begin
            @(negedge clk);
            if (k == 1 || k == 3) op_valid = 1'b0;
            chk(busy == (k <= n - 1), (n == 0) ? "R9" : "R8", "busy", 32'(busy), 32'(k <= n - 1));
            chk(done == (k == n), (n == 0) ? "R9" : req, "done", 32'(done), 32'(k == n));
            if (poke && k == 2) begin
                op_valid = 1'b1; op_sec = 1'b1; op_code = exp_en ? 8'hB2 : 8'hB3;
            end
        end
        exp_en = nxt_en;
        chk(brk_en == exp_en, (n == 0) ? "R9" : (poke ? "R8" : "R2"), "brk_en", 32'(brk_en), 32'(exp_en));
        if (n > 0) begin
            chk(wptr_out == ew, req, "wptr_out", wptr_out, ew);
            chk(iptr_out == ei, req, "iptr_out", iptr_out, ei);
        end
        if (swap) begin
            chk(log_q.size() == 4, "R7", "access count", 32'(log_q.size()), 32'd4);
            if (log_q.size() == 4) begin
                chk(!log_q[0].wr && log_q[0].a == a0, "R7", "1st read addr", log_q[0].a, a0);
                chk(!log_q[1].wr && log_q[1].a == a1, "R7", "2nd read addr", log_q[1].a, a1);
                chk(log_q[2].wr && log_q[2].a == a0 && log_q[2].d == wv, "R6", "wptr store", log_q[2].d, wv);
                chk(log_q[3].wr && log_q[3].a == a1 && log_q[3].d == iv, "R6", "iptr store", log_q[3].d, iv);
            end
        end else begin
            chk(log_q.size() == 0, (n == 0) ? "R9" : "R3", "no memory access", 32'(log_q.size()), 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        errors++;
        $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mem_m[BASE]      = 32'h0000_2000;
        mem_m[BASE + 4]  = 32'h0000_3000;
        mem_m[BASE + 8]  = 32'h0000_4000;
        mem_m[BASE + 12] = 32'h0000_5000;
        repeat (3) @(negedge clk);
        chk(brk_en == 0, "R1", "reset brk_en", 32'(brk_en), 0);
        chk(busy == 0 && done == 0, "R1", "reset busy/done", 32'({busy, done}), 0);
        chk(wptr_out == 0 && iptr_out == 0, "R1", "reset pointers", iptr_out, 0);
        chk(log_q.size() == 0, "R1", "no access in reset", 32'(log_q.size()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 8'h00, 32'h10, 1'b0, 32'h111, 32'h220, 0, "R3");
        run_op(1'b0, 8'h00, 32'h0, 1'b0, 32'h111, 32'h220, 0, "R3");
        run_op(1'b1, 8'hB1, 32'h0, 1'b0, 32'h100, 32'h200, 0, "R5");
        run_op(1'b1, 8'hB1, 32'h0, 1'b1, 32'h300, 32'h400, 0, "R5");
        run_op(1'b1, 8'hB3, 32'h0, 1'b0, 32'h777, 32'h888, 0, "R2");
        run_op(1'b0, 8'h00, 32'h0, 1'b0, 32'h500, 32'h600, 0, "R4");
        run_op(1'b0, 8'h00, 32'h0, 1'b1, 32'h700, 32'h800, 0, "R4");
        run_op(1'b0, 8'h00, 32'hFFFF_FFFC, 1'b0, 32'h900, 32'hA00, 0, "R3");
        run_op(1'b1, 8'hB1, 32'h0, 1'b0, 32'hB00, 32'hC00, 1, "R5");
        run_op(1'b1, 8'h55, 32'h0, 1'b0, 32'h1, 32'h2, 0, "R9");
        run_op(1'b0, 8'h20, 32'h0, 1'b0, 32'h1, 32'h2, 0, "R9");
        run_op(1'b1, 8'hB2, 32'h0, 1'b0, 32'h999, 32'hAAA, 0, "R2");
        run_op(1'b0, 8'h00, 32'h0, 1'b0, 32'hD00, 32'hE00, 0, "R3");
        run_op(1'b1, 8'hB1, 32'h0, 1'b1, 32'hF00, 32'hF10, 0, "R5");
        run_op(1'b1, 8'hB3, 32'h0, 1'b0, 32'h5, 32'h6, 0, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_en = 1'b0;
        chk(brk_en == 0, "R1", "reset clears flag", 32'(brk_en), 0);
        chk(busy == 0 && done == 0, "R1", "reset idle", 32'({busy, done}), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule